// File: doc/BRIEF.md
# Synchronous Serial Block Shifter

This block moves serial data on a three-wire synchronous link: a serial clock, a data output and a data input. A single start command moves anywhere from 1 to 256 bits. The 8-bit shift register is refilled from memory before each group of eight bits, and it is emptied into memory after each group. Memory is reached through two valid/ready byte streams. The transmit stream delivers the next byte to send. The receive stream takes each byte that has been assembled. Either side may stall, and the serial clock simply waits while a byte move is pending.

The port either makes its own serial clock or follows a clock from outside. Its own clock comes from an 8-bit half-period divider. An outside clock is passed through a synchronizer and reduced to edge events. The serial clock rests high whenever no bit is being shifted. Output data changes on the rising (trailing) edge, and input data is captured on the falling edge. Software sets the mode, the bit order, the clock source, the bit count and the divider through a small write-only register port. It then writes a start command and watches a done flag.

Transmit stream rules: `txb_ready` is high only while a byte is wanted. It stays high until `txb_valid` is seen, and the byte is taken on the clock edge where both are high. Receive stream rules: `rxb_valid` stays high with `rxb_data` held steady until the clock edge where `rxb_ready` is also high.

Top module: `sync_block_serial`

## Requirements
- R1: After reset, `sck_o` and `sdo` are high, `sck_oe` is high, and `done`, `txb_ready` and `rxb_valid` are low.
- R2: Bit order is set by bit 0 of the control register (address 0). When it is 1, bit 0 of each byte is sent first. When it is 0, bit 7 is sent first.
- R3: With the internal clock, each half period of `sck_o` lasts DIV+1 clock cycles, where DIV is the divider register (address 2). `sck_o` is high whenever no bit is being shifted.
- R4: `sdo` changes only on a rising edge of the serial clock. `sdi` is captured on the falling edge.
- R5: When bit 2 of the control register is 1 (block mode), a start moves COUNT+1 bits, from 1 to 256, where COUNT is the register at address 1. When that bit is 0, a start moves exactly 8 bits and COUNT is ignored.
- R6: One transmit byte is fetched before each group of up to 8 bits, and one received byte is stored after it. No serial clock edge occurs while a fetch or a store is pending.
- R7: A final group of k<8 bits is stored aligned to the bit order, with unused bits zero. LSB-first puts the first received bit at bit 0 and fills bits 0..k-1. MSB-first puts the first received bit at bit 7 and fills bits 7..8-k.
- R8: Writing address 3 with data bit 0 set starts a transfer only when the port is idle. A start clears `done`, and `done` rises once the last byte is stored. A start written while busy, or a write to address 3 with bit 0 clear, does nothing.
- R9: When bit 1 of the control register is 1, the port follows the serial clock from `sck_i`: `sck_oe` is low and bits move on the synchronized edges of `sck_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count, 2 divider, 3 start |
| reg_wdata | input | RW | Register write data |
| sck_i | input | 1 | Serial clock from outside |
| sck_o | output | 1 | Serial clock driven by the port |
| sck_oe | output | 1 | High when the port drives the serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| txb_valid | input | 1 | Transmit byte offered by memory |
| txb_ready | output | 1 | Port wants a transmit byte |
| txb_data | input | W | Transmit byte |
| rxb_valid | output | 1 | Received byte offered to memory |
| rxb_ready | input | 1 | Memory accepts the received byte |
| rxb_data | output | W | Received byte |
| done | output | 1 | Last transfer has completed |

## Verification
The bench aims at transfers of 1 bit, 9 bits and 256 bits, and at odd lengths in both bit orders. An error in the partial-group alignment shows up as a final received byte whose bits sit at the wrong end. An off-by-one in the bit count shows up as one falling edge too many or too few. Random stalls on both byte streams check that the clock freezes high. A port that kept shifting through a stall would send stale bits or repeat a fetch. A start written while busy, and a start command with its bit clear, must both leave the port alone. A design that queued either would raise `txb_ready` again after `done`. The outside-clock mode checks that the port stops driving the clock and still moves bits on the synchronized edges.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SHIFT, ST_STORE} sbs_state_e;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_COUNT = 2'd1;
  localparam logic [1:0] ADDR_DIV   = 2'd2;
  localparam logic [1:0] ADDR_GO    = 2'd3;

  typedef struct packed {
    logic blk_mode;
    logic ext_clk;
    logic lsb_first;
  } sbs_ctrl_t;
endpackage

// File: rtl/sbs_regs.sv
module sbs_regs
  import sbs_pkg::*;
#(
  parameter int RW    = 8,
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [RW-1:0]    wdata,
  output sbs_ctrl_t        ctrl,
  output logic [CNT_W-1:0] count,
  output logic [DIV_W-1:0] div,
  output logic             go
);
  sbs_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] count_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      count_q <= '0;
      div_q   <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_CTRL:  ctrl_q  <= sbs_ctrl_t'(wdata[2:0]);
        ADDR_COUNT: count_q <= wdata[CNT_W-1:0];
        ADDR_DIV:   div_q   <= wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  assign ctrl  = ctrl_q;
  assign count = count_q;
  assign div   = div_q;
  assign go    = wr && (addr == ADDR_GO) && wdata[0];
endmodule

// File: rtl/sbs_clkgen.sv
module sbs_clkgen #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] half_div,
  input  logic             sck_in,
  output logic             sck_o,
  output logic             sck_oe,
  output logic             fall_ev,
  output logic             rise_ev
);
  logic [DIV_W-1:0]       cnt_q;
  logic                   sck_q;
  logic                   tick;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ext_s;
  logic                   ext_prev_q;

  assign tick = run && !ext_mode && (cnt_q == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (!run || ext_mode) begin
      cnt_q <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sck_in;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], sck_in};
      end
    end
  endgenerate

  assign ext_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b1;
    else        ext_prev_q <= ext_s;
  end

  always_comb begin
    if (ext_mode) begin
      fall_ev = run && ext_prev_q && !ext_s;
      rise_ev = run && !ext_prev_q && ext_s;
    end else begin
      fall_ev = tick && sck_q;
      rise_ev = tick && !sck_q;
    end
  end

  assign sck_o  = sck_q;
  assign sck_oe = !ext_mode;

  // R3: a stopped generator returns the clock to its high rest level
  a_r3_stop_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sck_o);
  // R9: following an outside clock never toggles the driven clock
  a_r9_ext_driven_high: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |=> sck_o);
endmodule

// File: rtl/sbs_shifter.sv
module sbs_shifter #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [W-1:0]         load_data,
  input  logic                 lsb_first,
  input  logic                 fall_ev,
  input  logic                 rise_ev,
  input  logic                 grp_end,
  input  logic [$clog2(W)-1:0] grp_idx,
  input  logic                 sdi,
  output logic                 sdo_bit,
  output logic [W-1:0]         data
);
  localparam int GW = $clog2(W);
  localparam logic [GW-1:0] LAST = GW'(W - 1);

  logic [W-1:0]  sh_q;
  logic [W-1:0]  shifted;
  logic [W-1:0]  aligned;
  logic [GW-1:0] amt;
  logic          rx_bit_q;

  always_comb begin
    shifted = lsb_first ? {rx_bit_q, sh_q[W-1:1]} : {sh_q[W-2:0], rx_bit_q};
    amt     = LAST - grp_idx;
    aligned = lsb_first ? (shifted >> amt) : (shifted << amt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rx_bit_q <= 1'b0;
    else if (fall_ev) rx_bit_q <= sdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load)    sh_q <= load_data;
    else if (rise_ev) sh_q <= grp_end ? aligned : shifted;
  end

  assign sdo_bit = lsb_first ? sh_q[0] : sh_q[W-1];
  assign data    = sh_q;

  // R4: the shift register moves only on a rising serial edge or a load
  a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rise_ev) |=> $stable(sh_q));
  // R4: the input bit is taken from sdi at the falling edge
  a_r4_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ev |=> (rx_bit_q == $past(sdi)));
endmodule

// File: rtl/sync_block_serial.sv
module sync_block_serial
  import sbs_pkg::*;
#(
  parameter int W           = 8,
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 8,
  parameter int RW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sdi,
  output logic          sdo,
  input  logic          txb_valid,
  output logic          txb_ready,
  input  logic [W-1:0]  txb_data,
  output logic          rxb_valid,
  input  logic          rxb_ready,
  output logic [W-1:0]  rxb_data,
  output logic          done
);
  localparam int GW    = $clog2(W);
  localparam int REM_W = CNT_W + 1;

  sbs_state_e       st_q;
  sbs_ctrl_t        ctrl, act_q;
  logic [CNT_W-1:0] count;
  logic [DIV_W-1:0] div, div_q;
  logic             go;
  logic [REM_W-1:0] rem_q;
  logic [GW-1:0]    grp_q;
  logic             done_q;
  logic             fall_ev, rise_ev;
  logic             grp_end;
  logic             sdo_bit;
  logic             running;
  logic             load;

  sbs_regs #(.RW(RW), .CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl(ctrl), .count(count), .div(div), .go(go)
  );

  assign running = (st_q == ST_SHIFT);
  assign load    = (st_q == ST_FETCH) && txb_valid;
  assign grp_end = (grp_q == GW'(W - 1)) || (rem_q == REM_W'(1));

  sbs_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(running), .ext_mode(act_q.ext_clk),
    .half_div(div_q), .sck_in(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sbs_shifter #(.W(W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(txb_data),
    .lsb_first(act_q.lsb_first), .fall_ev(fall_ev), .rise_ev(rise_ev),
    .grp_end(grp_end), .grp_idx(grp_q), .sdi(sdi), .sdo_bit(sdo_bit),
    .data(rxb_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      act_q  <= '0;
      div_q  <= '0;
      rem_q  <= '0;
      grp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          act_q  <= ctrl;
          div_q  <= div;
          rem_q  <= ctrl.blk_mode ? ({1'b0, count} + REM_W'(1)) : REM_W'(W);
          done_q <= 1'b0;
          st_q   <= ST_FETCH;
        end
        ST_FETCH: if (txb_valid) begin
          grp_q <= '0;
          st_q  <= ST_SHIFT;
        end
        ST_SHIFT: if (rise_ev) begin
          rem_q <= rem_q - REM_W'(1);
          grp_q <= grp_q + 1'b1;
          if (grp_end) st_q <= ST_STORE;
        end
        ST_STORE: if (rxb_ready) begin
          if (rem_q == '0) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign txb_ready = (st_q == ST_FETCH);
  assign rxb_valid = (st_q == ST_STORE);
  assign sdo       = running ? sdo_bit : 1'b1;
  assign done      = done_q;

  // R3: the clock rests high outside the shifting phase
  a_r3_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> sck_o);
  // R6: a stored byte is held until memory takes it
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rxb_valid && !rxb_ready) |=> (rxb_valid && $stable(rxb_data)));
  // R6: a fetch request stays up until a byte arrives
  a_r6_tx_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (txb_ready && !txb_valid) |=> txb_ready);
  // R8: done only while neither stream is active
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!txb_ready && !rxb_valid && !running));
  // R5: remaining bit count never exceeds the largest transfer
  a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= REM_W'(1 << CNT_W));
endmodule

// File: tb/sync_block_serial_bench.sv
module sync_block_serial_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       sck_i, sck_o, sck_oe, sdi, sdo;
  logic       txb_valid, txb_ready, rxb_valid, rxb_ready, done;
  logic [7:0] txb_data, rxb_data;

  int checks = 0;
  int fails = 0;
  int bits_done;
  int falls;
  int n_bits;
  bit cur_lsb;
  logic [7:0] tx_mem [32];
  logic       peer [256];

  always #10 clk = ~clk;

  sync_block_serial u_sync_block_serial (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdi(sdi), .sdo(sdo), .txb_valid(txb_valid), .txb_ready(txb_ready),
    .txb_data(txb_data), .rxb_valid(rxb_valid), .rxb_ready(rxb_ready),
    .rxb_data(rxb_data), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL [%s] actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_tx_bit(input int i);
    logic [7:0] b = tx_mem[i/8];
    return cur_lsb ? b[i%8] : b[7 - i%8];
  endfunction

  function automatic logic [7:0] exp_rx_byte(input int j);
    logic [7:0] r = '0;
    int k = n_bits - 8*j;
    if (k > 8) k = 8;
    for (int p = 0; p < k; p++) begin
      if (cur_lsb) r[p] = peer[8*j + p];
      else         r[7 - p] = peer[8*j + p];
    end
    return r;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tx_server(input int nb, input int md);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      while (!txb_ready) @(negedge clk);
      check(bits_done == 8*i, "R6", bits_done, 8*i);
      repeat (md > 0 ? $urandom % (md + 1) : 0) @(negedge clk);
      check(sck_o == 1'b1, "R6", sck_o, 1);
      txb_valid = 1'b1; txb_data = tx_mem[i];
      @(negedge clk);
      txb_valid = 1'b0;
    end
  endtask

  task automatic rx_sink(input int nb, input int md);
    for (int j = 0; j < nb; j++) begin
      int expb;
      @(negedge clk);
      while (!rxb_valid) @(negedge clk);
      repeat (1 + (md > 0 ? $urandom % (md + 1) : 0)) @(negedge clk);
      expb = (8*(j+1) < n_bits) ? 8*(j+1) : n_bits;
      check(bits_done == expb, "R6", bits_done, expb);
      check(sck_o == 1'b1, "R3", sck_o, 1);
      if (n_bits - 8*j < 8)
        check(rxb_valid && rxb_data == exp_rx_byte(j), "R7", rxb_data, exp_rx_byte(j));
      else
        check(rxb_valid && rxb_data == exp_rx_byte(j), "R4", rxb_data, exp_rx_byte(j));
      rxb_ready = 1'b1;
      @(negedge clk);
      rxb_ready = 1'b0;
    end
  endtask

  task automatic int_monitor(input int dv);
    bit prev = 1'b1;
    int cyc = 0;
    int last_fall = 0;
    int idx = 0;
    while (idx < n_bits) begin
      @(negedge clk);
      cyc++;
      if (prev && !sck_o) begin
        check(sdo == exp_tx_bit(idx), "R2", sdo, exp_tx_bit(idx));
        if (idx % 8 != 0) check(cyc - last_fall == 2*(dv+1), "R3", cyc - last_fall, 2*(dv+1));
        last_fall = cyc;
        falls++;
      end else if (!prev && sck_o) begin
        idx++;
        bits_done = idx;
        if (idx < 256) sdi = peer[idx];
      end
      prev = sck_o;
    end
  endtask

  task automatic ext_driver();
    for (int i = 0; i < n_bits; i++) begin
      sdi = peer[i];
      repeat (16) @(negedge clk);
      check(sdo == exp_tx_bit(i), "R9", sdo, exp_tx_bit(i));
      sck_i = 1'b0;
      falls++;
      repeat (16) @(negedge clk);
      sck_i = 1'b1;
      bits_done = i + 1;
    end
  endtask

  task automatic run_xfer(input bit lsb, input bit ext, input bit blk, input int cnt,
                          input int dv, input int md, input bit poke);
    int nb;
    n_bits = blk ? cnt + 1 : 8;
    cur_lsb = lsb;
    nb = (n_bits + 7) / 8;
    bits_done = 0;
    falls = 0;
    for (int i = 0; i < 32; i++) tx_mem[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) peer[i] = 1'($urandom);
    sdi = peer[0];
    sck_i = 1'b1;
    reg_write(2'd0, {5'b0, blk, ext, lsb});
    reg_write(2'd1, 8'(cnt));
    reg_write(2'd2, 8'(dv));
    reg_write(2'd3, 8'h01);
    check(done == 1'b0, "R8", done, 0);
    check(sck_oe == !ext, "R9", sck_oe, !ext);
    fork
      tx_server(nb, ext ? 0 : md);
      rx_sink(nb, ext ? 0 : md);
      if (ext) ext_driver(); else int_monitor(dv);
      if (poke) begin
        repeat (6) @(negedge clk);
        reg_write(2'd1, 8'd200);
        reg_write(2'd3, 8'h01);
      end
    join
    check(falls == n_bits, "R5", falls, n_bits);
    check(done == 1'b1, "R8", done, 1);
    begin
      bit quiet = 1'b1;
      repeat (10) begin
        @(negedge clk);
        if (txb_ready || !sck_o) quiet = 1'b0;
      end
      check(quiet, "R8", quiet, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL [R8] watchdog expired: actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5EED);
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    sck_i = 1'b1; sdi = 1'b1; txb_valid = 1'b0; txb_data = '0; rxb_ready = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sck_o == 1'b1 && sdo == 1'b1, "R1", {sck_o, sdo}, 3);
    check(sck_oe == 1'b1, "R1", sck_oe, 1);
    check(!done && !txb_ready && !rxb_valid, "R1", {done, txb_ready, rxb_valid}, 0);

    // R8: start command with bit 0 clear is ignored
    reg_write(2'd3, 8'h00);
    repeat (5) @(negedge clk);
    check(!txb_ready && sck_o, "R8", txb_ready, 0);

    run_xfer(1, 0, 1, 0,   1, 0, 0);  // R5 single bit, LSB first
    run_xfer(0, 0, 1, 0,   0, 0, 0);  // single bit, MSB first
    run_xfer(1, 0, 1, 8,   2, 2, 0);  // R7 9 bits
    run_xfer(0, 0, 1, 12,  0, 2, 0);  // R7 13 bits MSB
    run_xfer(1, 0, 1, 255, 0, 1, 0);  // R5 256 bits
    run_xfer(0, 0, 0, 3,   5, 0, 0);  // R5 single-byte mode, count ignored; R3 div 5
    run_xfer(1, 0, 1, 20,  1, 3, 1);  // R8 start while busy ignored
    run_xfer(0, 1, 1, 12,  0, 0, 0);  // R9 outside clock, MSB
    run_xfer(1, 1, 1, 9,   0, 0, 0);  // R9 outside clock, LSB
    for (int t = 0; t < 16; t++)
      run_xfer(1'($urandom), 0, 1, $urandom % 256, $urandom % 4, 3, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule